// File: doc/BRIEF.md
# Linked-Descriptor Receive DMA Engine

This engine moves incoming frames from a byte stream into memory buffers. The buffers are described by a chain of four-word descriptors in memory. Each descriptor holds a parameter word, a pointer to the next descriptor, a buffer address and a status word. The last descriptor points back to the first, so the chain forms a ring.

After a start command, the engine reads a descriptor. If software still owns that descriptor, the engine waits and polls it again. Otherwise it packs frame bytes into 32-bit writes to the buffer. When the frame ends, it writes a completion status into the descriptor and then follows the next pointer. A stop command takes the channel off-line.

Software hands a descriptor to the engine by clearing its hold bit. The engine hands it back by setting the complete bit in the status word.

Top module: `rx_ring_dma`

## Requirements
- R1: A start command (`cmd_code` 2'b01) given while the channel is off loads `first_addr` with its low 4 bits forced to zero. The engine then reads, in order, the parameter word (+0), the next pointer (+4) and the buffer address (+8) of that descriptor.
- R2: If bit 31 (hold) of a fetched parameter word is 1, the engine reads no other word of that descriptor and accepts no data. After each such read it makes no memory request for poll+1 cycles, then reads the parameter word again. The poll register resets to 7 and is loaded from `poll_val` when `poll_wr` is high.
- R3: Frame byte n is written to byte lane n mod 4 (bits 8k+7:8k) of the word at (buffer address with bits 1:0 cleared) + 4*(n/4). A final partial word enables only the lanes it fills.
- R4: At the end of a frame the engine writes the word at descriptor+12, with this layout:
  - bit 31 (complete) = 1
  - bit 30 (start of packet) = 1
  - bit 29 (end of packet) = 1 for a frame that fits
  - bits 28:17 = 0
  - bits 16:0 = count of every byte from SOP to EOP inclusive, trailing CRC included.
- R5: After the status write, the engine fetches the descriptor at the next-pointer word with its low 4 bits forced to zero. The ring therefore wraps through the pointer and not by index.
- R6: Bits 21:0 of the parameter word give the buffer size. For a frame longer than that size:
  - the extra bytes are not stored;
  - the status count equals the size, with end of packet 0 and complete 1;
  - the remaining bytes up to EOP are accepted and discarded;
  - the next descriptor starts only with a new SOP.
- R7: Bytes that arrive outside a frame without SOP are accepted and discarded.
- R8: A stop command (`cmd_code` 2'b10) returns the channel to off once any memory access in flight has been acknowledged. After that there are no memory requests, and `rx_ready` is low.
- R9: `busy` is 0 after reset. It is high from the start command until the channel is off. A start command given while `busy` is high is ignored.
- R10: A memory request keeps its address, direction, write data and byte enables stable until `mem_ack`.
- R11: `rx_ready` is high only while the engine waits for frame bytes or discards a truncated frame. It is low during descriptor fetch, hold wait and memory writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Channel command strobe |
| cmd_code | input | 2 | 2'b01 start, 2'b10 stop, others ignored |
| first_addr | input | 32 | Address of the first descriptor |
| poll_wr | input | 1 | Load strobe for the poll interval |
| poll_val | input | POLL_W | New poll interval in cycles |
| rx_valid | input | 1 | Stream byte valid |
| rx_data | input | 8 | Stream byte |
| rx_sop | input | 1 | Byte is the first of a frame |
| rx_eop | input | 1 | Byte is the last of a frame |
| rx_ready | output | 1 | Engine accepts the stream byte |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte lane enables for writes |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| busy | output | 1 | Channel is on |

## Verification
The bench builds the engine with POLL_W = 4 and the default poll reset value of 7. The first hold wait therefore runs on the reset interval, and reprogramming to 2 shows a shorter gap between re-reads. A three-descriptor ring, with small buffer sizes and next pointers whose low bits are set, brings the following within a few hundred cycles:
- truncation;
- a partial final word;
- discarding of stray bytes;
- wrap-around back to the first descriptor.

// File: rtl/rx_ring_dma.sv
module rx_ring_dma #(
  parameter int POLL_W = 8,
  parameter int POLL_RESET = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_code,
  input  logic [31:0]       first_addr,
  input  logic              poll_wr,
  input  logic [POLL_W-1:0] poll_val,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_sop,
  input  logic              rx_eop,
  output logic              rx_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_be,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              busy
);
  localparam logic [1:0] CMD_START = 2'b01;
  localparam logic [1:0] CMD_STOP  = 2'b10;
  localparam int SIZE_W = 22;
  localparam int CNT_W  = 17;

  typedef enum logic [2:0] {
    S_OFF, S_RD_PAR, S_RD_NXT, S_RD_BUF, S_HOLD, S_RECV, S_WR_DAT, S_WR_STA
  } state_t;

  state_t              state;
  logic [27:0]         cur_d, nxt_d;
  logic [29:0]         wptr;
  logic [SIZE_W-1:0]   size_q, cnt;
  logic [31:0]         wbuf;
  logic [3:0]          be;
  logic [POLL_W-1:0]   poll, pcnt;
  logic                inframe, drop, fin, eopf, stop_pend;
  logic                unused_lo;

  wire [1:0] lane     = cnt[1:0];
  wire       acc      = rx_valid && rx_ready;
  wire       stop_req = busy && (stop_pend || (cmd_valid && cmd_code == CMD_STOP));
  wire       can_stop = !mem_req || mem_ack;
  wire       take     = acc && !drop && (inframe || rx_sop);
  wire [31:0] status  = {1'b1, 1'b1, eopf, 12'd0, cnt[CNT_W-1:0]};

  assign unused_lo = ^first_addr[3:0];
  assign busy      = state != S_OFF;
  assign rx_ready  = drop || state == S_RECV;
  assign mem_req   = state inside {S_RD_PAR, S_RD_NXT, S_RD_BUF, S_WR_DAT, S_WR_STA};
  assign mem_we    = state inside {S_WR_DAT, S_WR_STA};
  assign mem_be    = state == S_WR_STA ? 4'hF : state == S_WR_DAT ? be : 4'h0;
  assign mem_wdata = state == S_WR_STA ? status : state == S_WR_DAT ? wbuf : 32'd0;

  always_comb begin
    case (state)
      S_RD_PAR: mem_addr = {cur_d, 4'h0};
      S_RD_NXT: mem_addr = {cur_d, 4'h4};
      S_RD_BUF: mem_addr = {cur_d, 4'h8};
      S_WR_STA: mem_addr = {cur_d, 4'hC};
      S_WR_DAT: mem_addr = {wptr, 2'b00};
      default:  mem_addr = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_OFF;
      cur_d     <= '0;
      nxt_d     <= '0;
      wptr      <= '0;
      size_q    <= '0;
      cnt       <= '0;
      wbuf      <= '0;
      be        <= '0;
      poll      <= POLL_W'(POLL_RESET);
      pcnt      <= '0;
      inframe   <= 1'b0;
      drop      <= 1'b0;
      fin       <= 1'b0;
      eopf      <= 1'b0;
      stop_pend <= 1'b0;
    end else begin
      if (poll_wr) poll <= poll_val;
      if (acc && drop && rx_eop) drop <= 1'b0;
      if (stop_req && can_stop) begin
        state     <= S_OFF;
        stop_pend <= 1'b0;
        drop      <= 1'b0;
        inframe   <= 1'b0;
        be        <= '0;
        fin       <= 1'b0;
      end else begin
        if (stop_req) stop_pend <= 1'b1;
        case (state)
          S_OFF: if (cmd_valid && cmd_code == CMD_START) begin
            cur_d <= first_addr[31:4];
            state <= S_RD_PAR;
          end
          S_RD_PAR: if (mem_ack) begin
            if (mem_rdata[31]) begin
              pcnt  <= poll;
              state <= S_HOLD;
            end else begin
              size_q <= mem_rdata[SIZE_W-1:0];
              state  <= S_RD_NXT;
            end
          end
          S_HOLD: begin
            if (pcnt == '0) state <= S_RD_PAR;
            else pcnt <= pcnt - POLL_W'(1);
          end
          S_RD_NXT: if (mem_ack) begin
            nxt_d <= mem_rdata[31:4];
            state <= S_RD_BUF;
          end
          S_RD_BUF: if (mem_ack) begin
            wptr    <= mem_rdata[31:2];
            cnt     <= '0;
            be      <= '0;
            wbuf    <= '0;
            fin     <= 1'b0;
            eopf    <= 1'b0;
            inframe <= 1'b0;
            state   <= S_RECV;
          end
          S_RECV: if (take) begin
            if (cnt == size_q) begin
              inframe <= 1'b0;
              eopf    <= 1'b0;
              fin     <= 1'b1;
              drop    <= !rx_eop;
              state   <= (be != 4'h0) ? S_WR_DAT : S_WR_STA;
            end else begin
              wbuf[{lane, 3'b000} +: 8] <= rx_data;
              be[lane] <= 1'b1;
              cnt      <= cnt + SIZE_W'(1);
              inframe  <= !rx_eop;
              if (rx_eop) begin
                eopf  <= 1'b1;
                fin   <= 1'b1;
                state <= S_WR_DAT;
              end else if (lane == 2'd3) begin
                state <= S_WR_DAT;
              end
            end
          end
          S_WR_DAT: if (mem_ack) begin
            be    <= '0;
            wbuf  <= '0;
            wptr  <= wptr + 30'd1;
            state <= fin ? S_WR_STA : S_RECV;
          end
          S_WR_STA: if (mem_ack) begin
            cur_d <= nxt_d;
            state <= S_RD_PAR;
          end
          default: state <= S_OFF;
        endcase
      end
    end
  end
endmodule

// File: rtl/rx_ring_dma_chk.sv
module rx_ring_dma_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_ack,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic [3:0]  mem_be,
  input logic [31:0] mem_rdata,
  input logic        rx_ready,
  input logic        drop,
  input logic        cmd_valid,
  input logic [1:0]  cmd_code
);
  p_first_fetch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> mem_req && !mem_we && mem_addr[3:0] == 4'h0);

  p_hold_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mem_req && mem_ack && !mem_we && mem_addr[3:2] == 2'b00 && mem_rdata[31])
      |-> !mem_req);

  p_write_lanes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_be != 4'h0);

  p_stop_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_code == 2'b10 && busy && !mem_req |=> !busy);

  p_off_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !rx_ready);

  p_req_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
      && $stable(mem_wdata) && $stable(mem_be));

  p_ready_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !drop |-> !rx_ready);
endmodule

bind rx_ring_dma rx_ring_dma_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
  .mem_ack(mem_ack), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
  .mem_rdata(mem_rdata), .rx_ready(rx_ready), .drop(drop),
  .cmd_valid(cmd_valid), .cmd_code(cmd_code)
);

// File: tb/rx_ring_dma_tb_top.sv
`timescale 1ns/1ps
module rx_ring_dma_tb_top;
  localparam int PW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_code = 2'b00;
  logic [31:0] first_addr = 32'd0;
  logic poll_wr = 1'b0;
  logic [PW-1:0] poll_val = '0;
  logic rx_valid = 1'b0, rx_sop = 1'b0, rx_eop = 1'b0;
  logic [7:0] rx_data = 8'd0;
  logic rx_ready, mem_req, mem_we, mem_ack, busy;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0] mem_be;

  always #2 clk = ~clk;

  rx_ring_dma #(.POLL_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .first_addr(first_addr), .poll_wr(poll_wr), .poll_val(poll_val),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_sop(rx_sop), .rx_eop(rx_eop),
    .rx_ready(rx_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .busy(busy)
  );

  logic [31:0] mem [0:1023];
  logic poke_en = 1'b0;
  logic [31:0] poke_addr = 32'd0, poke_data = 32'd0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      for (int i = 0; i < 1024; i++) mem[i] <= 32'hAAAA_AAAA;
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && mem_ack && mem_we)
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[11:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
      if (poke_en) mem[poke_addr[11:2]] <= poke_data;
    end
  end
  assign mem_rdata = mem[mem_addr[11:2]];

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int lcnt = 0, n110 = 0, t110_prev = 0, t110_last = 0, viol = 0;
  logic [31:0] log_addr [0:511];
  logic prev_pend = 1'b0;
  logic [31:0] prev_addr = 32'd0;
  always @(negedge clk) begin
    if (prev_pend && (!mem_req || mem_addr != prev_addr)) viol <= viol + 1;
    prev_pend <= mem_req && !mem_ack;
    prev_addr <= mem_addr;
    if (mem_req && mem_ack) begin
      if (lcnt < 512) begin
        log_addr[lcnt] <= mem_addr;
        lcnt <= lcnt + 1;
      end
      if (!mem_we && mem_addr == 32'h110) begin
        t110_prev <= t110_last;
        t110_last <= cyc;
        n110 <= n110 + 1;
      end
    end
  end

  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    poke_en = 1'b1; poke_addr = a; poke_data = d;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  task automatic command(input logic [1:0] code, input logic [31:0] a);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = code; first_addr = a;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_code = 2'b00;
  endtask

  task automatic send_byte(input logic [7:0] d, input logic s, input logic e);
    rx_valid = 1'b1; rx_data = d; rx_sop = s; rx_eop = e;
    forever begin
      if (rx_ready) begin
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] base, input int len);
    for (int i = 0; i < len; i++)
      send_byte(base + 8'(i), i == 0, i == len - 1);
  endtask

  task automatic wait_status(input logic [31:0] a, input string req);
    int n = 0;
    while (!mem[a[11:2]][31] && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk({req, " status written"}, 32'(n < 2000), 32'd1);
  endtask

  task automatic test_reset();
    chk("R9 busy after reset", 32'(busy), 32'd0);
    chk("R8 no request while off", 32'(mem_req), 32'd0);
    chk("R11 not ready while off", 32'(rx_ready), 32'd0);
  endtask

  task automatic test_first_frame();
    int idx;
    poke(32'h100, 32'h0000_0040); poke(32'h104, 32'h0000_0113);
    poke(32'h108, 32'h0000_0200); poke(32'h10C, 32'h0);
    poke(32'h110, 32'h8000_0005); poke(32'h114, 32'h0000_0120);
    poke(32'h118, 32'h0000_0300); poke(32'h11C, 32'h0);
    poke(32'h120, 32'h6000_0040); poke(32'h124, 32'h0000_010F);
    poke(32'h128, 32'h0000_0400); poke(32'h12C, 32'h0);
    idx = lcnt;
    command(2'b01, 32'h105);
    chk("R9 busy after start", 32'(busy), 32'd1);
    send_frame(8'h11, 6);
    wait_status(32'h10C, "R4");
    chk("R1 first fetch param", log_addr[idx], 32'h100);
    chk("R1 first fetch next", log_addr[idx+1], 32'h104);
    chk("R1 first fetch buffer", log_addr[idx+2], 32'h108);
    chk("R3 full word lanes", mem[32'h200 >> 2], 32'h1413_1211);
    chk("R3 partial word lanes", mem[32'h204 >> 2], 32'hAAAA_1615);
    chk("R4 status full frame", mem[32'h10C >> 2], 32'hE000_0006);
  endtask

  task automatic test_hold();
    int n;
    poke(32'h10C, 32'h0);
    n = 0;
    while (n110 < 3 && n < 500) begin @(negedge clk); n++; end
    chk("R2 hold polls reset interval", 32'(t110_last - t110_prev), 32'd10);
    chk("R11 not ready during hold", 32'(rx_ready), 32'd0);
    chk("R2 hold leaves status", mem[32'h11C >> 2], 32'h0);
    @(negedge clk);
    poll_wr = 1'b1; poll_val = 4'd2;
    @(negedge clk);
    poll_wr = 1'b0;
    command(2'b01, 32'h300);
    n = n110 + 3;
    while (n110 < n) @(negedge clk);
    chk("R2 hold polls new interval", 32'(t110_last - t110_prev), 32'd5);
    chk("R9 start ignored while busy", 32'(busy), 32'd1);
  endtask

  task automatic test_truncate();
    poke(32'h110, 32'h0000_0005);
    send_frame(8'hA0, 7);
    wait_status(32'h11C, "R6");
    chk("R6 truncated status", mem[32'h11C >> 2], 32'hC000_0005);
    chk("R6 first word kept", mem[32'h300 >> 2], 32'hA3A2_A1A0);
    chk("R6 excess not stored", mem[32'h304 >> 2], 32'hAAAA_AAA4);
  endtask

  task automatic test_stray();
    send_byte(8'hEE, 1'b0, 1'b0);
    send_byte(8'hEF, 1'b0, 1'b0);
    send_frame(8'hC0, 4);
    wait_status(32'h12C, "R7");
    chk("R7 stray bytes dropped", mem[32'h400 >> 2], 32'hC3C2_C1C0);
    chk("R3 no write past frame", mem[32'h404 >> 2], 32'hAAAA_AAAA);
    chk("R4 count includes CRC bytes", mem[32'h12C >> 2], 32'hE000_0004);
  endtask

  task automatic test_wrap();
    send_frame(8'hD5, 1);
    wait_status(32'h10C, "R5");
    chk("R5 wrap status", mem[32'h10C >> 2], 32'hE000_0001);
    chk("R3 single lane enable", mem[32'h200 >> 2], 32'h1413_12D5);
  endtask

  task automatic test_stop_restart();
    int idx, n;
    repeat (10) @(negedge clk);
    command(2'b10, 32'h0);
    repeat (2) @(negedge clk);
    chk("R8 busy low after stop", 32'(busy), 32'd0);
    idx = lcnt;
    repeat (20) @(negedge clk);
    chk("R8 no accesses after stop", 32'(lcnt - idx), 32'd0);
    chk("R8 not ready after stop", 32'(rx_ready), 32'd0);
    command(2'b01, 32'h12A);
    n = 0;
    while (lcnt == idx && n < 100) begin @(negedge clk); n++; end
    chk("R1 restart ignores low bits", log_addr[idx], 32'h120);
    command(2'b10, 32'h0);
    repeat (4) @(negedge clk);
    chk("R8 stop during fetch", 32'(busy), 32'd0);
    chk("R10 request held until ack", 32'(viol), 32'd0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_first_frame();
    test_hold();
    test_truncate();
    test_stray();
    test_wrap();
    test_stop_restart();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (R1..): actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule